// File: doc/BRIEF.md
# Quad-Lane Dual-Edge Burst Read Engine

This block adds a high-throughput read mode to a serial flash controller. In normal operation the engine listens on one lane. There it looks for a two-byte entry command: the opcode D4h followed by an 8-bit mode byte. When chip select rises after exactly those sixteen bits, the engine switches into quad mode.

In quad mode all four lanes carry information, and every SCK transition counts, rising and falling alike. Each access starts with a 24-bit start address, delivered four bits per edge. After a programmable latency in half-clock steps, the engine returns 16-bit words from an internal word store. The mode byte selects the burst form: either continuous, or wrapping inside an aligned group of 4, 8, 16 or 32 words.

Raising chip select ends an access and keeps the mode byte. One special address returns the engine to single-lane operation: its low half is 55AAh, and chip select must rise while SCK is low. The word store is filled through a synchronous write port. The pins are sampled by the block clock, which must run several times faster than SCK.

Top module: `hd_quad_read`

## Requirements
- R1: Quad mode is entered only when chip select rises after exactly 16 single-lane bits, taken on SCK rising edges and lane 0 first-bit-MSB, whose first byte is D4h; the second byte becomes the mode byte. Any other opcode or bit count leaves `hd_mode` low.
- R2: In quad mode the address is taken on six consecutive SCK edges of either polarity, four bits per edge. The first edge carries A23..A20 on lanes 3..0 and the sixth carries A3..A0. The word index is A[WORD_AW:1].
- R3: Each word is sent as four nibbles on consecutive edges, D15..D12 first, with lane 3 carrying the highest bit of each nibble.
- R4: With latency code c in mode bits [2:0], the first nibble appears on edge c+3 after the last address edge. Codes 6 and 7 behave as code 5.
- R5: With mode bits [7:5] = 000 the word index rises by one per word and wraps from the top of the store to word 0.
- R6: With mode bits [7:5] = 1gg the index advances inside the aligned group of 4, 8, 16 or 32 words (gg = 00, 01, 10, 11) and returns to the group's first word.
- R7: A chip-select rise stops the burst and releases the lanes. The next access needs a new address and uses the kept mode byte.
- R8: An address with low 16 bits 55AAh, followed by a chip-select rise while SCK is low, returns to single-lane mode. Any other address, or SCK high at the rise, keeps quad mode.
- R9: `lanes_oe` is never high while chip select is high, nor during the address and latency edges.
- R10: After reset the engine is in single-lane mode with the lanes released.
- R11: A word written through the store port is returned by later bursts at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| lanes_i | input | 4 | Lane input levels; lane 0 is the single-lane data input |
| lanes_o | output | 4 | Lane output levels in quad data phase |
| lanes_oe | output | 1 | Lane output enable |
| hd_mode | output | 1 | High while quad mode is active (pad role select) |
| mem_we | input | 1 | Word store write enable |
| mem_waddr | input | WORD_AW | Word store write index |
| mem_wdata | input | 16 | Word store write data |

## Verification
A wrong edge count in the address or latency phase shows up at once as a shifted nibble stream. In that case the first driven nibble lands one or more edges early or late. A wrong pointer update appears at the first word boundary after a group edge or store top, within four SCK edges. Mode entry and exit faults are visible on `hd_mode` within two block clocks of the chip-select rise.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [1:0] {PH_ADDR = 2'd0, PH_LAT = 2'd1, PH_DATA = 2'd2} hd_phase_e;

  localparam logic [7:0]  ENTER_OP = 8'hD4;
  localparam logic [15:0] EXIT_KEY = 16'h55AA;
  localparam int unsigned ADDR_EDGES = 6;

  // edge index (after the last address edge) carrying the first nibble
  function automatic logic [3:0] lat_target(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'd5) ? 3'd5 : code;
    return 4'(c) + 4'd3;
  endfunction
endpackage

// File: rtl/hd_pin_sampler.sv
module hd_pin_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] lanes_i,
  output logic       cs_hi,
  output logic       cs_rise,
  output logic       sck_lvl,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic [3:0] lanes_s
);
  logic cs_q1, cs_q2, sck_q1, sck_q2;
  logic [3:0] lanes_q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q1    <= 1'b1;
      cs_q2    <= 1'b1;
      sck_q1   <= 1'b0;
      sck_q2   <= 1'b0;
      lanes_q1 <= '0;
    end else begin
      cs_q1    <= cs_n;
      cs_q2    <= cs_q1;
      sck_q1   <= sck;
      sck_q2   <= sck_q1;
      lanes_q1 <= lanes_i;
    end
  end

  assign cs_hi    = cs_q1;
  assign cs_rise  = cs_q1 & ~cs_q2;
  assign sck_lvl  = sck_q1;
  assign sck_rise = sck_q1 & ~sck_q2;
  assign sck_fall = ~sck_q1 & sck_q2;
  assign lanes_s  = lanes_q1;
endmodule

// File: rtl/hd_cmd_decoder.sv
module hd_cmd_decoder
  import hd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cs_hi,
  input  logic       cs_rise,
  input  logic       sck_rise,
  input  logic       si,
  output logic       enter,
  output logic [7:0] mode_byte
);
  localparam logic [4:0] BITS_SAT = 5'd17;

  logic [15:0] shift_q, shift_d;
  logic [4:0]  bits_q, bits_d;

  always_comb begin
    shift_d = shift_q;
    bits_d  = bits_q;
    if (cs_hi) begin
      bits_d = '0;
    end else if (en && sck_rise) begin
      shift_d = {shift_q[14:0], si};
      bits_d  = (bits_q == BITS_SAT) ? BITS_SAT : bits_q + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
    end else begin
      shift_q <= shift_d;
      bits_q  <= bits_d;
    end
  end

  // R1: exactly sixteen bits, entry opcode first
  assign enter     = en && cs_rise && (bits_q == 5'd16) && (shift_q[15:8] == ENTER_OP);
  assign mode_byte = shift_q[7:0];

  assert_bit_count_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BITS_SAT);
endmodule

// File: rtl/hd_word_store.sv
module hd_word_store #(
  parameter int WORD_AW = 8,
  localparam int DEPTH = 1 << WORD_AW
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [15:0]        wdata,
  input  logic [WORD_AW-1:0] raddr,
  output logic [15:0]        rdata
);
  logic [15:0] mem_q [DEPTH];

  // R11: plain synchronous write, asynchronous read
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/hd_lane_sequencer.sv
module hd_lane_sequencer
  import hd_pkg::*;
#(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               cs_hi,
  input  logic               sck_edge,
  input  logic [3:0]         lanes_s,
  input  logic [2:0]         burst,
  input  logic [2:0]         lat_code,
  input  logic [15:0]        rd_word,
  output logic [WORD_AW-1:0] rd_ptr,
  output logic [3:0]         lanes_o,
  output logic               lanes_oe,
  output logic               addr_done,
  output logic [23:0]        addr_q
);
  hd_phase_e          phase_q, phase_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [1:0]         nib_q, nib_d;
  logic [WORD_AW-1:0] ptr_q, ptr_d, ptr_next, grp_mask;
  logic [23:0]        addr_d, addr_full;
  logic [3:0]         out_q, out_d, nibble;
  logic               oe_q, oe_d, emit;
  logic               unused_addr;

  assign addr_full   = {addr_q[19:0], lanes_s};
  assign unused_addr = ^{addr_full[23:WORD_AW+1], addr_full[0]};

  always_comb begin
    case (burst[1:0])
      2'd0:    grp_mask = WORD_AW'(3);
      2'd1:    grp_mask = WORD_AW'(7);
      2'd2:    grp_mask = WORD_AW'(15);
      default: grp_mask = WORD_AW'(31);
    endcase
  end

  // R5/R6: continuous count or aligned-group wrap
  always_comb begin
    if (burst[2]) ptr_next = (ptr_q & ~grp_mask) | ((ptr_q + 1'b1) & grp_mask);
    else          ptr_next = ptr_q + 1'b1;
  end

  // R3: D15..D12 first
  always_comb begin
    case (nib_q)
      2'd0:    nibble = rd_word[15:12];
      2'd1:    nibble = rd_word[11:8];
      2'd2:    nibble = rd_word[7:4];
      default: nibble = rd_word[3:0];
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    nib_d   = nib_q;
    ptr_d   = ptr_q;
    addr_d  = addr_q;
    out_d   = out_q;
    oe_d    = oe_q;
    emit    = 1'b0;
    if (!active || cs_hi) begin
      phase_d = PH_ADDR;   // R7: fresh address needed
      cnt_d   = '0;
      nib_d   = '0;
      oe_d    = 1'b0;
      out_d   = '0;
    end else if (sck_edge) begin
      unique case (phase_q)
        PH_ADDR: begin     // R2
          addr_d = addr_full;
          if (cnt_q == 4'(ADDR_EDGES - 1)) begin
            phase_d = PH_LAT;
            cnt_d   = '0;
            ptr_d   = addr_full[WORD_AW:1];
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        PH_LAT: begin      // R4
          if (cnt_q + 4'd1 == lat_target(lat_code)) begin
            phase_d = PH_DATA;
            emit    = 1'b1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        default: emit = 1'b1;
      endcase
      if (emit) begin
        out_d = nibble;
        oe_d  = 1'b1;
        nib_d = nib_q + 2'd1;
        if (nib_q == 2'd3) ptr_d = ptr_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      nib_q   <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      out_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      nib_q   <= nib_d;
      ptr_q   <= ptr_d;
      addr_q  <= addr_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign rd_ptr    = ptr_q;
  assign lanes_o   = out_q;
  assign lanes_oe  = oe_q;
  assign addr_done = (phase_q != PH_ADDR);

  assert_no_drive_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !oe_q);
  assert_drive_only_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (phase_q == PH_DATA));
  assert_addr_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> (cnt_q < 4'(ADDR_EDGES)));
  assert_latency_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LAT) |-> (cnt_q < 4'd8));
  assert_wrap_in_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_hi && sck_edge && phase_q == PH_DATA && nib_q == 2'd3 && burst[2])
    |=> ((ptr_q & ~grp_mask) == $past(ptr_q & ~grp_mask)));
endmodule

// File: rtl/hd_quad_read.sv
module hd_quad_read
  import hd_pkg::*;
#(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic [3:0]         lanes_i,
  output logic [3:0]         lanes_o,
  output logic               lanes_oe,
  output logic               hd_mode,
  input  logic               mem_we,
  input  logic [WORD_AW-1:0] mem_waddr,
  input  logic [15:0]        mem_wdata
);
  logic cs_hi, cs_rise, sck_lvl, sck_rise, sck_fall;
  logic [3:0] lanes_s;
  logic enter, exit_hit, addr_done;
  logic [7:0] mode_byte, mode_q, mode_d;
  logic active_q, active_d;
  logic [23:0] seq_addr;
  logic [WORD_AW-1:0] rd_ptr;
  logic [15:0] rd_word;
  logic unused_bits;

  // mode bits [4:3] are the clock class: held, no effect on sequencing
  assign unused_bits = ^{mode_q[4:3], seq_addr[23:16]};

  hd_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .lanes_i(lanes_i),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_lvl(sck_lvl),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .lanes_s(lanes_s)
  );

  hd_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .en(!active_q), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .si(lanes_s[0]), .enter(enter), .mode_byte(mode_byte)
  );

  hd_word_store #(.WORD_AW(WORD_AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_ptr), .rdata(rd_word)
  );

  hd_lane_sequencer #(.WORD_AW(WORD_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active_q), .cs_hi(cs_hi),
    .sck_edge(sck_rise | sck_fall), .lanes_s(lanes_s),
    .burst(mode_q[7:5]), .lat_code(mode_q[2:0]), .rd_word(rd_word),
    .rd_ptr(rd_ptr), .lanes_o(lanes_o), .lanes_oe(lanes_oe),
    .addr_done(addr_done), .addr_q(seq_addr)
  );

  // R8: release key with SCK low at the chip-select rise
  assign exit_hit = active_q && cs_rise && addr_done &&
                    (seq_addr[15:0] == EXIT_KEY) && !sck_lvl;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    if (enter) begin
      active_d = 1'b1;
      mode_d   = mode_byte;
    end else if (exit_hit) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;   // R10
      mode_q   <= '0;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
    end
  end

  assign hd_mode = active_q;

  assert_enter_on_cs_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(cs_rise));
  assert_exit_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(seq_addr[15:0] == EXIT_KEY));
  assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(mode_q));
endmodule

// File: tb/test_hd_quad_read.sv
module test_hd_quad_read;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic clk, rst_n, cs_n, sck, mem_we, lanes_oe, hd_mode;
  logic [3:0] lanes_i, lanes_o;
  logic [AW-1:0] mem_waddr;
  logic [15:0] mem_wdata;
  logic [15:0] model [NW];
  int checks, fails;

  hd_quad_read #(.WORD_AW(AW)) i_hd_quad_read (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .lanes_i(lanes_i),
    .lanes_o(lanes_o), .lanes_oe(lanes_oe), .hd_mode(hd_mode),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sample the result of the previous edge, then drive and toggle SCK
  task automatic hedge(input logic [3:0] drv, output logic [3:0] d, output logic o);
    repeat (3) @(negedge clk);
    d = lanes_o;
    o = lanes_oe;
    lanes_i = drv;
    @(negedge clk);
    sck = ~sck;
  endtask

  task automatic cs_low();
    if (sck) begin
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [7:0] md, input int nbits);
    logic [15:0] v;
    logic [3:0] d;
    logic o;
    v = {op, md};
    cs_low();
    for (int i = 0; i < nbits; i++) begin
      hedge({3'b000, v[15-i]}, d, o);
      hedge(4'h0, d, o);
    end
    cs_high();
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [3:0] d;
    logic o;
    for (int e = 0; e < 6; e++) hedge(a[23-4*e -: 4], d, o);
  endtask

  // gbits = 0 continuous, else log2 of the group size
  task automatic burst(input logic [23:0] a, input int code, input int nwords,
                       input int gbits, input string tag);
    logic [3:0] d;
    logic o;
    int lat, start, idx, w, n, p, m;
    logic [15:0] wd;
    lat = ((code > 5) ? 5 : code) + 3;
    start = int'(a[AW:1]);
    m = (gbits == 0) ? (NW - 1) : ((1 << gbits) - 1);
    cs_low();
    send_addr(a);
    for (int k = 0; k <= lat - 1 + 4 * nwords; k++) begin
      hedge(4'h0, d, o);
      if (k < lat) begin
        chk(o == 1'b0, "R9 no drive in address/latency", {31'd0, o}, 32'd0);
      end else begin
        idx = k - lat;
        w = idx / 4;
        n = idx % 4;
        p = (start & ~m) | ((start + w) & m);
        wd = model[p];
        chk(o == 1'b1 && d == wd[15-4*n -: 4], tag, {27'd0, o, d},
            {27'd0, 1'b1, wd[15-4*n -: 4]});
      end
    end
  endtask

  task automatic do_exit();
    cs_low();
    send_addr(24'h0055AA);
    cs_high();
    chk(hd_mode == 1'b0, "R8 release key", {31'd0, hd_mode}, 32'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic o;
    checks = 0; fails = 0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; lanes_i = '0;
    mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(hd_mode == 1'b0 && lanes_oe == 1'b0, "R10 reset state", {30'd0, hd_mode, lanes_oe}, 32'd0);

    for (int i = 0; i < NW; i++) begin
      model[i] = 16'(i * 40503) ^ 16'h5A5A;
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = model[i];
      @(negedge clk);
    end
    mem_we = 1'b0;

    // R1 negatives
    send_cmd(8'hD5, 8'h01, 16);
    chk(hd_mode == 1'b0, "R1 wrong opcode", {31'd0, hd_mode}, 32'd0);
    send_cmd(8'hD4, 8'h00, 8);
    chk(hd_mode == 1'b0, "R1 short command", {31'd0, hd_mode}, 32'd0);
    cs_low();
    for (int e = 0; e < 12; e++) begin
      hedge(4'hF, d, o);
      chk(o == 1'b0, "R10 no drive in single-lane mode", {31'd0, o}, 32'd0);
    end
    cs_high();

    // R4 latency sweep, continuous
    for (int c = 0; c < 8; c++) begin
      send_cmd(8'hD4, {3'b000, 2'b10, 3'(c)}, 16);
      chk(hd_mode == 1'b1, "R1 entry", {31'd0, hd_mode}, 32'd1);
      burst(24'h000040, c, 3, 0, "R4 latency / R3 nibble order");
      cs_high();
      do_exit();
    end

    // R6 wrap groups, R7 mode kept across accesses
    for (int g = 0; g < 4; g++) begin
      send_cmd(8'hD4, {1'b1, 2'(g), 2'b01, 3'b001}, 16);
      burst(24'h000086, 1, (4 << g) + 3, g + 2, "R6 wrap group");
      cs_high();
      chk(lanes_oe == 1'b0, "R7 lanes released", {31'd0, lanes_oe}, 32'd0);
      burst(24'h0000F6, 1, (4 << g) + 2, g + 2, "R7 mode kept, R6 wrap");
      cs_high();
      do_exit();
    end

    // R5 continuous across the top of the store, R2 address nibbles
    send_cmd(8'hD4, 8'h02, 16);
    burst(24'h0001FA, 2, 5, 0, "R5 continuous top wrap");
    cs_high();
    burst(24'h00A5C2, 2, 2, 0, "R2 address capture");
    cs_high();

    // R11 store rewrite seen by later burst
    model[8'h61] = 16'hBEEF;
    mem_we = 1'b1; mem_waddr = 8'h61; mem_wdata = 16'hBEEF;
    @(negedge clk);
    mem_we = 1'b0;
    burst(24'h0000C2, 2, 1, 0, "R11 rewritten word");
    cs_high();

    // R8 negatives: near key, and key with SCK high at the rise
    cs_low(); send_addr(24'h0055A8); cs_high();
    chk(hd_mode == 1'b1, "R8 other address keeps mode", {31'd0, hd_mode}, 32'd1);
    cs_low(); send_addr(24'h0055AA); hedge(4'h0, d, o); cs_high();
    chk(hd_mode == 1'b1, "R8 SCK high keeps mode", {31'd0, hd_mode}, 32'd1);
    burst(24'h000010, 2, 2, 0, "R8 still in quad mode");
    cs_high();
    do_exit();
    cs_low();
    for (int e = 0; e < 20; e++) begin
      hedge(4'hA, d, o);
      chk(o == 1'b0, "R8 single-lane after release", {31'd0, o}, 32'd0);
    end
    cs_high();

    summary();
    $finish;
  end
endmodule